// File: doc/BRIEF.md
# Processor Subsystem Boot/Reset Sequencer

This block moves an embedded processor subsystem out of its held, powered-down state into execution, and back again. A single-cycle boot command, with a 32-bit entry address, starts the bring-up order. A single-cycle shutdown command starts the tear-down order. Both orders are fixed. The block drives one 32-bit control word that carries individual reset, clock-enable, memory-enable, I/O clamp and core-stop bits. It also loads a 20-bit exception-vector base and two strap words before it lets the core run.

Each intermediate control word stays on the output for at least one full clock. After the reset assertion in either order, a settling interval counted in bus clock cycles (parameter `WAIT_CYC`, default 8) must pass before the next step. While an order is in progress the block reports busy. When an order completes it raises a one-cycle done pulse.

Control-word bit positions: core stop 26, I/O clamp 25, subsystem reset 23, debug reset 22, trace reset 21, core reset 10, memory enables 9 (L1), 8 (TCM core) and 7 (TCM peripheral), core clock enable 2. All other bits are always 0. Below, the "reset set" means bits 23, 22, 21 and 10, and the "memory set" means bits 9, 8 and 7.

Top module: `proc_boot_seq`

## Requirements
- R1: After rst_ni is asserted, ctrl_o is the reset set plus the stop and clamp bits, with memories and clock off. vec_base_o, strap_tcm_o and strap_bus_o read 0, and busy_o and done_o read 0.
- R2: A command accepted at clock edge k changes ctrl_o at edge k, in one update. The update sets the reset set and the stop bit and clears the clock enable. All other bits, the clamp included, keep their previous values.
- R3: In a boot, ctrl_o holds the R2 word for WAIT_CYC cycles. At edge k+WAIT_CYC the clock enable and the memory set become 1.
- R4: At edge k+WAIT_CYC+1 of a boot, the clamp bit and the reset set clear, and the stop bit stays 1.
- R5: At edge k+WAIT_CYC+2 of a boot, vec_base_o takes bits [31:12] of the boot address sampled at edge k. At the same edge strap_tcm_o takes 0x0146_028B and strap_bus_o takes 0x0029_0280. ctrl_o does not change at that edge.
- R6: At edge k+WAIT_CYC+3 of a boot, the stop bit clears. This is the last change of the boot.
- R7: In a shutdown, ctrl_o holds the R2 word for WAIT_CYC cycles. At edge k+WAIT_CYC the memory set clears.
- R8: At edge k+WAIT_CYC+1 of a shutdown, the clamp bit sets, one cycle after the memories turned off.
- R9: busy_o is 1 from edge k until the final step of the order, and 0 in the cycle where the final step shows on ctrl_o.
- R10: done_o is 1 for exactly the one cycle in which the final step of either order first shows on ctrl_o.
- R11: boot_req_i and shut_req_i have no effect while busy_o is 1. The running order proceeds unchanged.
- R12: If boot_req_i and shut_req_i are both 1 while idle, the boot order runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_req_i | input | 1 | Start bring-up order |
| shut_req_i | input | 1 | Start tear-down order |
| boot_addr_i | input | 32 | Boot entry address, sampled when a boot is accepted |
| ctrl_o | output | 32 | Subsystem control word |
| vec_base_o | output | 20 | Exception-vector base (entry address bits [31:12]) |
| strap_tcm_o | output | 32 | Tightly-coupled memory strap word |
| strap_bus_o | output | 32 | Bus strap word |
| busy_o | output | 1 | An order is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase state shows up at once on ctrl_o, because every step writes a distinct word that the bench compares on every cycle of every order. A wrong settling count shifts the memory-enable edge by one or more cycles, so the check at cycle WAIT_CYC catches it. A wrong address capture shows on vec_base_o one cycle before the core is released. A dropped or stretched done or busy edge is seen in the same cycle as the final control-word change.

// File: rtl/proc_boot_seq_pkg.sv
package proc_boot_seq_pkg;
  localparam int unsigned CW = 32;
  localparam int unsigned BIT_STOP    = 26;
  localparam int unsigned BIT_CLAMP   = 25;
  localparam int unsigned BIT_SS_RST  = 23;
  localparam int unsigned BIT_DBG_RST = 22;
  localparam int unsigned BIT_TRC_RST = 21;
  localparam int unsigned BIT_CORE_RST = 10;
  localparam int unsigned BIT_MEM_L1  = 9;
  localparam int unsigned BIT_MEM_TCM = 8;
  localparam int unsigned BIT_MEM_PER = 7;
  localparam int unsigned BIT_CLK_EN  = 2;

  localparam logic [CW-1:0] M_STOP  = 32'h1 << BIT_STOP;
  localparam logic [CW-1:0] M_CLAMP = 32'h1 << BIT_CLAMP;
  localparam logic [CW-1:0] M_CLK   = 32'h1 << BIT_CLK_EN;
  localparam logic [CW-1:0] M_RST   = (32'h1 << BIT_SS_RST) | (32'h1 << BIT_DBG_RST)
                                    | (32'h1 << BIT_TRC_RST) | (32'h1 << BIT_CORE_RST);
  localparam logic [CW-1:0] M_MEM   = (32'h1 << BIT_MEM_L1) | (32'h1 << BIT_MEM_TCM)
                                    | (32'h1 << BIT_MEM_PER);
  localparam logic [CW-1:0] CTRL_RESET = M_RST | M_STOP | M_CLAMP;

  typedef enum logic [2:0] {
    ST_IDLE, ST_B_WAIT, ST_B_REL, ST_B_VEC, ST_B_GO, ST_S_WAIT, ST_S_CLAMP
  } seq_state_e;
endpackage

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int unsigned WAIT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int unsigned TW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [TW-1:0] LAST = TW'(WAIT_CYC - 1);

  logic          run_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == LAST);
endmodule

// File: rtl/boot_vec_regs.sv
module boot_vec_regs #(
  parameter int unsigned AW = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [31:0] STRAP_TCM = 32'h0146_028B,
  parameter logic [31:0] STRAP_BUS = 32'h0029_0280
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [AW-1:0]           addr_i,
  output logic [AW-PAGE_BITS-1:0] vec_base_o,
  output logic [31:0]             strap_tcm_o,
  output logic [31:0]             strap_bus_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_base_o  <= '0;
      strap_tcm_o <= '0;
      strap_bus_o <= '0;
    end else if (load_i) begin
      vec_base_o  <= addr_i[AW-1:PAGE_BITS];
      strap_tcm_o <= STRAP_TCM;
      strap_bus_o <= STRAP_BUS;
    end
  end
endmodule

// File: rtl/proc_boot_seq.sv
module proc_boot_seq
  import proc_boot_seq_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    boot_req_i,
  input  logic                    shut_req_i,
  input  logic [AW-1:0]           boot_addr_i,
  output logic [CW-1:0]           ctrl_o,
  output logic [AW-PAGE_BITS-1:0] vec_base_o,
  output logic [31:0]             strap_tcm_o,
  output logic [31:0]             strap_bus_o,
  output logic                    busy_o,
  output logic                    done_o
);
  seq_state_e    st_q;
  logic [CW-1:0] ctrl_q;
  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          start, expire, load_vec;

  assign start    = (st_q == ST_IDLE) && (boot_req_i || shut_req_i);
  assign load_vec = (st_q == ST_B_VEC);

  seq_settle_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .expire_o(expire)
  );

  boot_vec_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_vec), .addr_i(addr_q),
    .vec_base_o(vec_base_o), .strap_tcm_o(strap_tcm_o), .strap_bus_o(strap_bus_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctrl_q <= CTRL_RESET;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          ctrl_q <= (ctrl_q | M_RST | M_STOP) & ~M_CLK;
          if (boot_req_i) begin  // boot wins a tie
            addr_q <= boot_addr_i;
            st_q   <= ST_B_WAIT;
          end else begin
            st_q   <= ST_S_WAIT;
          end
        end
        ST_B_WAIT: if (expire) begin
          ctrl_q <= ctrl_q | M_CLK | M_MEM;
          st_q   <= ST_B_REL;
        end
        ST_B_REL: begin
          ctrl_q <= ctrl_q & ~(M_CLAMP | M_RST);
          st_q   <= ST_B_VEC;
        end
        ST_B_VEC: st_q <= ST_B_GO;
        ST_B_GO: begin
          ctrl_q <= ctrl_q & ~M_STOP;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_S_WAIT: if (expire) begin
          ctrl_q <= ctrl_q & ~M_MEM;
          st_q   <= ST_S_CLAMP;
        end
        ST_S_CLAMP: begin
          ctrl_q <= ctrl_q | M_CLAMP;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  assert_stop_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[BIT_STOP]) |-> done_o && !ctrl_o[BIT_CORE_RST] && ctrl_o[BIT_CLK_EN]);

  assert_clamp_after_mem_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[BIT_CLAMP]) |-> (ctrl_o & M_MEM) == '0 && done_o);

  assert_mem_under_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[BIT_MEM_L1]) |-> ctrl_o[BIT_CORE_RST] && ctrl_o[BIT_STOP]
                                  && $past(!ctrl_o[BIT_CLK_EN]));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_release_keeps_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[BIT_CORE_RST]) |-> ctrl_o[BIT_STOP] && busy_o);
endmodule

// File: tb/proc_boot_seq_test.sv
module proc_boot_seq_test;
  import proc_boot_seq_pkg::*;
  localparam int unsigned W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_req = 1'b0, shut_req = 1'b0;
  logic [31:0] boot_addr = '0;
  logic [31:0] ctrl, strap_tcm, strap_bus;
  logic [19:0] vec_base;
  logic        busy, done;

  int checks = 0, errors = 0;
  logic [31:0] cur;       // expected control word
  logic [19:0] cur_vec;
  logic [31:0] cur_tcm, cur_bus;

  always #4 clk = ~clk;

  proc_boot_seq #(.WAIT_CYC(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .boot_req_i(boot_req), .shut_req_i(shut_req),
    .boot_addr_i(boot_addr), .ctrl_o(ctrl), .vec_base_o(vec_base),
    .strap_tcm_o(strap_tcm), .strap_bus_o(strap_bus), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // boot; interfere pulses other commands mid-run (R11); both raises both requests (R12)
  task automatic do_boot(input logic [31:0] a, input bit interfere, input bit both);
    logic [31:0] held, memw, relw, runw;
    held = (cur | M_RST | M_STOP) & ~M_CLK;
    memw = held | M_CLK | M_MEM;
    relw = memw & ~(M_CLAMP | M_RST);
    runw = relw & ~M_STOP;
    @(negedge clk);
    boot_req = 1'b1; shut_req = both; boot_addr = a;
    @(negedge clk);
    boot_req = 1'b0; shut_req = 1'b0; boot_addr = ~a;  // capture at accept only (R5)
    for (int j = 0; j <= 12; j++) begin
      if (j > 0) @(negedge clk);
      if (interfere && j == 3) shut_req = 1'b1;
      if (interfere && j == 4) begin shut_req = 1'b0; boot_req = 1'b1; boot_addr = 32'hDEAD_B000; end
      if (interfere && j == 5) boot_req = 1'b0;
      if (j < W)                    chk(both ? "R12 held" : "R2 held", ctrl, held);
      else if (j == W)              chk("R3 mem on", ctrl, memw);
      else if (j == W+1 || j == W+2) chk("R4 release", ctrl, relw);
      else                          chk(interfere ? "R11 run" : "R6 run", ctrl, runw);
      chk("R9 busy", {31'b0, busy}, {31'b0, j <= W+2});
      chk("R10 done", {31'b0, done}, {31'b0, j == W+3});
      if (j < W+2) chk("R5 vec before load", {12'b0, vec_base}, {12'b0, cur_vec});
      else begin
        chk("R5 vec", {12'b0, vec_base}, {12'b0, a[31:12]});
        chk("R5 strap tcm", strap_tcm, 32'h0146_028B);
        chk("R5 strap bus", strap_bus, 32'h0029_0280);
      end
    end
    cur = runw; cur_vec = a[31:12];
  endtask

  task automatic do_shut(input bit interfere);
    logic [31:0] held, offw, clw;
    held = (cur | M_RST | M_STOP) & ~M_CLK;
    offw = held & ~M_MEM;
    clw  = offw | M_CLAMP;
    @(negedge clk);
    shut_req = 1'b1;
    @(negedge clk);
    shut_req = 1'b0;
    for (int j = 0; j <= 10; j++) begin
      if (j > 0) @(negedge clk);
      if (interfere && j == 2) boot_req = 1'b1;
      if (interfere && j == 3) boot_req = 1'b0;
      if (j < W)       chk("R7 held", ctrl, held);
      else if (j == W) chk("R7 mem off", ctrl, offw);
      else             chk(interfere ? "R11 clamp" : "R8 clamp", ctrl, clw);
      chk("R9 busy", {31'b0, busy}, {31'b0, j < W+1});
      chk("R10 done", {31'b0, done}, {31'b0, j == W+1});
      chk("R11 vec kept", {12'b0, vec_base}, {12'b0, cur_vec});
    end
    cur = clw;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur = CTRL_RESET; cur_vec = '0; cur_tcm = '0; cur_bus = '0;
    repeat (3) @(negedge clk);
    chk("R1 ctrl", ctrl, 32'h06E0_0400);
    chk("R1 vec", {12'b0, vec_base}, 32'h0);
    chk("R1 tcm", strap_tcm, cur_tcm);
    chk("R1 bus", strap_bus, cur_bus);
    chk("R1 busy/done", {30'b0, busy, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", ctrl, CTRL_RESET);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = (i == 0) ? 32'h0 : (i == 7) ? 32'hFFFF_FFFF : (32'h1357_9BDF * i) ^ (32'h1 << (i * 4));
      do_boot(a, i[0], i == 3);
      if (i == 5) do_boot(a ^ 32'h0F0F_0000, 1'b0, 1'b0);  // boot while running
      do_shut(i[1]);
    end
    do_shut(1'b0);  // shutdown from already shut-down state

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", ctrl, CTRL_RESET);
    chk("R1 re-reset vec", {12'b0, vec_base}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule